// File: doc/BRIEF.md
# Device Bus Channel Sequencer

This block is the channel end of a shared, multidrop device bus. The processor side hands it one command at a time. The command holds a device number, a direction, a write byte and a response time limit. The block then runs two interlocked steps on the bus: a selection step and a data step. Each step raises one line and holds it until the addressed device answers. The step ends when the channel drops the line and both response lines have fallen again. No step assumes a fixed delay, so slow and fast devices share the same bus.

Three checks guard the exchange. A response limit ends a step that goes unanswered. A response that does not fit the current step counts as an ordering fault. Read bytes carry odd parity, and the block checks it. Each operation finishes with a one-cycle done pulse and a 3-bit outcome code for the processor. When a fault occurs, the block first drops its lines and waits for the bus to go quiet before it reports the outcome.

Top module: `chan_handshake_ctrl`

## Requirements
- R1: After reset, cmd_ready is 1, while bus_sel, bus_strobe and op_done are 0 and op_cc is 0.
- R2: A command is accepted in a cycle where cmd_valid and cmd_ready are both 1. From the next cycle, bus_sel is 1 and bus_dev equals the command's 8-bit device number. bus_dev_par makes the 9 bits {bus_dev, bus_dev_par} hold an odd count of ones. cmd_ready stays 0 until op_done.
- R3: bus_sel stays high until dev_ack or dev_busy is sampled high, and falls in the next cycle. bus_strobe rises only after dev_ack and dev_busy have both been sampled low. bus_strobe is never high together with bus_sel.
- R4: A clean exchange ends with op_cc = 0. For a read, op_rdata holds the bus_din byte sampled with dev_ack during the data step.
- R5: If dev_busy alone answers the selection step, op_cc = 1 and no data step follows.
- R6: With a nonzero limit L, a response sampled within the first L cycles of a step's line being high is accepted. This includes the L-th cycle itself. Otherwise the line falls after exactly L cycles and op_cc = 2. A limit of 0 disables the check.
- R7: dev_ack and dev_busy high together in the selection step, or dev_busy high in the data step, give op_cc = 3. This outcome takes precedence over a parity fault.
- R8: For a read, if {bus_din, bus_din_par} holds an even count of ones when dev_ack arrives in the data step, op_cc = 4.
- R9: After any outcome, bus_sel and bus_strobe are low. op_done pulses for one cycle only after dev_ack and dev_busy have both been sampled low. cmd_ready is 1 again in the op_done cycle.
- R10: During the data step of a write, bus_wr is 1 and bus_dout holds the command byte, with bus_dout_par giving odd parity over the 9 bits. bus_wr is 0 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Channel idle, command taken this cycle if offered |
| cmd_rd | input | 1 | 1 = read from device, 0 = write |
| cmd_dev | input | 8 | Device number |
| cmd_wdata | input | 8 | Write byte |
| tmo_limit | input | 16 | Response limit in cycles, 0 = none |
| bus_dev | output | 8 | Device number on the bus |
| bus_dev_par | output | 1 | Odd parity for bus_dev |
| bus_sel | output | 1 | Selection step line |
| bus_strobe | output | 1 | Data step line |
| bus_wr | output | 1 | Direction of the data step |
| bus_dout | output | 8 | Write byte on the bus |
| bus_dout_par | output | 1 | Odd parity for bus_dout |
| bus_din | input | 8 | Read byte from the device |
| bus_din_par | input | 1 | Parity bit for bus_din |
| dev_ack | input | 1 | Device accepts the current step |
| dev_busy | input | 1 | Device declines selection |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_cc | output | 3 | Outcome code |
| op_rdata | output | 8 | Last byte read cleanly |

## Verification
Two events can land in the same cycle: a response from the device and expiry of the response limit. The bench makes the device answer after exactly L-1 idle cycles, so its response is sampled in the limit cycle itself, and then after L idle cycles. The first case must be a clean step and the second a timeout, with the line dropping after exactly L cycles. A busy response is also sent together with a read byte of bad parity. Here the ordering fault must win over the parity fault.

// File: rtl/chan_pkg.sv
package chan_pkg;

  typedef enum logic [2:0] {
    CC_OK   = 3'd0,
    CC_BUSY = 3'd1,
    CC_TMO  = 3'd2,
    CC_SEQ  = 3'd3,
    CC_PAR  = 3'd4
  } cc_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_SREL = 3'd2,
    ST_DAT  = 3'd3,
    ST_DREL = 3'd4,
    ST_EREL = 3'd5
  } st_e;

endpackage

// File: rtl/chan_par_gen.sv
module chan_par_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  output logic         par
);
  // odd parity: the bit that makes data plus bit hold an odd count of ones
  assign par = ~(^data);
endmodule

// File: rtl/chan_par_chk.sv
module chan_par_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         par,
  output logic         ok
);
  assign ok = ^{data, par};
endmodule

// File: rtl/chan_wait_timer.sv
module chan_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] lim,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (lim != '0) && (cnt_q == lim - 1'b1);

  // R6: a waiting step never runs past its limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lim != '0) |-> (cnt_q < lim));

endmodule

// File: rtl/chan_seq_fsm.sv
module chan_seq_fsm
  import chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rd,
  input  logic ack,
  input  logic busy,
  input  logic rx_ok,
  input  logic tmo,
  output st_e  state,
  output logic set_cc,
  output cc_e  cc_val,
  output logic cap_rd,
  output logic done_d
);
  st_e st_q, st_d;
  logic quiet;

  assign quiet = !ack && !busy;

  always_comb begin
    st_d   = st_q;
    set_cc = 1'b0;
    cc_val = CC_OK;
    cap_rd = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go) st_d = ST_SEL;
      ST_SEL: begin
        if (ack && busy) begin
          set_cc = 1'b1; cc_val = CC_SEQ; st_d = ST_EREL;
        end else if (busy) begin
          set_cc = 1'b1; cc_val = CC_BUSY; st_d = ST_EREL;
        end else if (ack) begin
          st_d = ST_SREL;
        end else if (tmo) begin
          set_cc = 1'b1; cc_val = CC_TMO; st_d = ST_EREL;
        end
      end
      ST_SREL: if (quiet) st_d = ST_DAT;
      ST_DAT: begin
        if (busy) begin
          set_cc = 1'b1; cc_val = CC_SEQ; st_d = ST_EREL;
        end else if (ack) begin
          if (rd && !rx_ok) begin
            set_cc = 1'b1; cc_val = CC_PAR; st_d = ST_EREL;
          end else begin
            cap_rd = rd; st_d = ST_DREL;
          end
        end else if (tmo) begin
          set_cc = 1'b1; cc_val = CC_TMO; st_d = ST_EREL;
        end
      end
      ST_DREL, ST_EREL: if (quiet) begin
        st_d = ST_IDLE; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R3: the data line rises only once the bus has been seen quiet
  a_r3_strobe_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DAT && $past(st_q) != ST_DAT) |-> $past(quiet));

  // R9: completion is reported only after the bus has gone quiet
  a_r9_done_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) != ST_IDLE) |-> $past(quiet));

  // R5: a decline ends the selection step in the next cycle
  a_r5_busy_ends_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL && busy) |=> (st_q == ST_EREL));

endmodule

// File: rtl/chan_handshake_ctrl.sv
module chan_handshake_ctrl
  import chan_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_rd,
  input  logic [AW-1:0] cmd_dev,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [TW-1:0] tmo_limit,
  output logic [AW-1:0] bus_dev,
  output logic          bus_dev_par,
  output logic          bus_sel,
  output logic          bus_strobe,
  output logic          bus_wr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_par,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_din_par,
  input  logic          dev_ack,
  input  logic          dev_busy,
  output logic          op_done,
  output logic [2:0]    op_cc,
  output logic [DW-1:0] op_rdata
);
  st_e           state;
  logic          accept, set_cc, cap_rd, done_d, rx_ok, tmo, run;
  cc_e           cc_val, cc_q, cc_d;
  logic [AW-1:0] dev_q, dev_d;
  logic [DW-1:0] wd_q, wd_d, rdat_q, rdat_d;
  logic [TW-1:0] lim_q, lim_d;
  logic          rd_q, rd_d, done_q;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign run       = (state == ST_SEL) || (state == ST_DAT);

  chan_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(cmd_valid), .rd(rd_q),
    .ack(dev_ack), .busy(dev_busy), .rx_ok(rx_ok), .tmo(tmo),
    .state(state), .set_cc(set_cc), .cc_val(cc_val),
    .cap_rd(cap_rd), .done_d(done_d)
  );

  chan_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .lim(lim_q), .expired(tmo)
  );

  chan_par_gen #(.W(AW)) u_apar (.data(dev_q), .par(bus_dev_par));
  chan_par_gen #(.W(DW)) u_wpar (.data(wd_q),  .par(bus_dout_par));
  chan_par_chk #(.W(DW)) u_rchk (.data(bus_din), .par(bus_din_par), .ok(rx_ok));

  // command capture, clock enable written out
  always_comb begin
    dev_d = dev_q;
    wd_d  = wd_q;
    rd_d  = rd_q;
    lim_d = lim_q;
    if (accept) begin
      dev_d = cmd_dev;
      wd_d  = cmd_wdata;
      rd_d  = cmd_rd;
      lim_d = tmo_limit;
    end
  end

  always_comb begin
    cc_d = cc_q;
    if (accept)      cc_d = CC_OK;
    else if (set_cc) cc_d = cc_val;
  end

  always_comb begin
    rdat_d = rdat_q;
    if (cap_rd) rdat_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      wd_q   <= '0;
      rd_q   <= 1'b0;
      lim_q  <= '0;
      cc_q   <= CC_OK;
      rdat_q <= '0;
      done_q <= 1'b0;
    end else begin
      dev_q  <= dev_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      lim_q  <= lim_d;
      cc_q   <= cc_d;
      rdat_q <= rdat_d;
      done_q <= done_d;
    end
  end

  assign bus_dev    = dev_q;
  assign bus_dout   = wd_q;
  assign bus_wr     = !rd_q;
  assign bus_sel    = (state == ST_SEL);
  assign bus_strobe = (state == ST_DAT);
  assign op_done    = done_q;
  assign op_cc      = cc_q;
  assign op_rdata   = rdat_q;

  // R2: the device number does not move while selection is held
  a_r2_dev_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && $past(bus_sel)) |-> $stable(bus_dev));

  // R9: the outcome code does not change between operations
  a_r9_cc_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_done) && !accept && cmd_ready) |=> $stable(op_cc));

endmodule

// File: tb/chan_handshake_ctrl_tb_top.sv
module chan_handshake_ctrl_tb_top;
  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_rd;
  logic [7:0] cmd_dev, cmd_wdata;
  logic [15:0] tmo_limit;
  logic [7:0] bus_dev, bus_dout, bus_din, op_rdata;
  logic bus_dev_par, bus_sel, bus_strobe, bus_wr, bus_dout_par, bus_din_par;
  logic dev_ack, dev_busy, op_done;
  logic [2:0] op_cc;
  int errors, checks;

  chan_handshake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rd(cmd_rd), .cmd_dev(cmd_dev), .cmd_wdata(cmd_wdata),
    .tmo_limit(tmo_limit), .bus_dev(bus_dev), .bus_dev_par(bus_dev_par),
    .bus_sel(bus_sel), .bus_strobe(bus_strobe), .bus_wr(bus_wr),
    .bus_dout(bus_dout), .bus_dout_par(bus_dout_par), .bus_din(bus_din),
    .bus_din_par(bus_din_par), .dev_ack(dev_ack), .dev_busy(dev_busy),
    .op_done(op_done), .op_cc(op_cc), .op_rdata(op_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int odd9(input logic [7:0] d, input logic p);
    return $countones({d, p}) % 2;
  endfunction

  function automatic int exp_cc(input bit rd, input int lim, input int sd, input bit busy,
                                input bit sseq, input int dd, input bit dseq, input bit badp);
    if (lim != 0 && sd >= lim) return 2;
    if (sseq) return 3;
    if (busy) return 1;
    if (lim != 0 && dd >= lim) return 2;
    if (dseq) return 3;
    if (rd && badp) return 4;
    return 0;
  endfunction

  task automatic wait_done();
    int g = 0;
    while (!op_done && g < 40) begin @(negedge clk); g++; end
    chk(op_done == 1'b1, "R9 done pulse seen", op_done, 1);
    chk(cmd_ready == 1'b1, "R9 ready with done", cmd_ready, 1);
  endtask

  task automatic run_op(input bit rd, input logic [7:0] dev, input logic [7:0] wd,
                        input int lim, input int sd, input bit busy, input bit sseq,
                        input int dd, input bit dseq, input bit badp,
                        input logic [7:0] rdv, input int hold);
    int e, cnt;
    bit sel_fail;
    e = exp_cc(rd, lim, sd, busy, sseq, dd, dseq, badp);
    sel_fail = (lim != 0 && sd >= lim) || sseq || busy;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_dev = dev; cmd_wdata = wd; tmo_limit = 16'(lim);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_dev = ~dev; tmo_limit = 16'hffff;
    chk(bus_sel == 1'b1, "R2 sel rises", bus_sel, 1);
    chk(bus_dev == dev, "R2 device number", int'(bus_dev), int'(dev));
    chk(odd9(bus_dev, bus_dev_par) == 1, "R2 address parity", odd9(bus_dev, bus_dev_par), 1);
    chk(cmd_ready == 1'b0, "R2 ready low", cmd_ready, 0);
    // selection step
    cnt = 0;
    while (cnt < sd && bus_sel) begin @(negedge clk); cnt++; end
    if (!bus_sel) begin
      chk(lim != 0 && cnt == lim, "R6 sel dropped at limit", cnt, lim);
      wait_done();
      chk(int'(op_cc) == e, "R6 timeout code", op_cc, e);
      return;
    end
    dev_ack = !busy || sseq; dev_busy = busy || sseq;
    @(negedge clk);
    chk(bus_sel == 1'b0, "R3 sel falls after response", bus_sel, 0);
    for (int h = 0; h < hold; h++) begin
      chk(!bus_strobe && !op_done, "R3 waits for quiet", bus_strobe, 0);
      @(negedge clk);
    end
    dev_ack = 1'b0; dev_busy = 1'b0;
    if (sel_fail) begin
      wait_done();
      chk(int'(op_cc) == e, "R5 R7 selection outcome", op_cc, e);
      return;
    end
    // data step
    begin
      int g = 0;
      while (!bus_strobe && g < 20) begin @(negedge clk); g++; end
    end
    chk(bus_strobe == 1'b1 && bus_sel == 1'b0, "R3 strobe after quiet", bus_strobe, 1);
    chk(bus_wr == !rd, "R10 direction", bus_wr, !rd);
    if (!rd) begin
      chk(bus_dout == wd, "R10 write byte", bus_dout, wd);
      chk(odd9(bus_dout, bus_dout_par) == 1, "R10 write parity", odd9(bus_dout, bus_dout_par), 1);
    end
    cnt = 0;
    while (cnt < dd && bus_strobe) begin @(negedge clk); cnt++; end
    if (!bus_strobe) begin
      chk(lim != 0 && cnt == lim, "R6 strobe dropped at limit", cnt, lim);
      wait_done();
      chk(int'(op_cc) == e, "R6 data timeout code", op_cc, e);
      return;
    end
    dev_ack = 1'b1; dev_busy = dseq;
    bus_din = rdv; bus_din_par = badp ? ^rdv : ~(^rdv);
    @(negedge clk);
    chk(bus_strobe == 1'b0, "R9 strobe falls", bus_strobe, 0);
    for (int h = 0; h < hold; h++) begin
      chk(!op_done, "R9 no done before quiet", op_done, 0);
      @(negedge clk);
    end
    dev_ack = 1'b0; dev_busy = 1'b0; bus_din = 8'h00;
    wait_done();
    chk(int'(op_cc) == e, "R4 R7 R8 outcome", op_cc, e);
    if (e == 0 && rd) chk(op_rdata == rdv, "R4 read data", op_rdata, rdv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned sd0;
    errors = 0; checks = 0;
    sd0 = $urandom(32'd2024);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_rd = 1'b0; cmd_dev = '0; cmd_wdata = '0;
    tmo_limit = '0; bus_din = '0; bus_din_par = 1'b0; dev_ack = 1'b0; dev_busy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !bus_sel && !bus_strobe && !op_done && op_cc == 0,
        "R1 reset state", {cmd_ready, bus_sel, bus_strobe, op_done}, 8);
    // directed corners
    run_op(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, 8'h5a, 0);  // R4 read
    run_op(0, 8'hff, 8'h81, 0, 3, 0, 0, 2, 0, 0, 8'h00, 2);  // R10 write
    run_op(1, 8'h12, 8'h00, 4, 3, 0, 0, 3, 0, 0, 8'hc3, 1);  // R6 response in limit cycle
    run_op(1, 8'h12, 8'h00, 4, 4, 0, 0, 0, 0, 0, 8'h00, 0);  // R6 sel timeout
    run_op(0, 8'h34, 8'h0f, 3, 0, 0, 0, 3, 0, 0, 8'h00, 0);  // R6 data timeout
    run_op(1, 8'h20, 8'h00, 1, 0, 0, 0, 0, 0, 0, 8'h77, 0);  // R6 limit one
    run_op(1, 8'h21, 8'h00, 0, 9, 0, 0, 9, 0, 0, 8'h99, 0);  // R6 disabled
    run_op(0, 8'h44, 8'h00, 0, 1, 1, 0, 0, 0, 0, 8'h00, 2);  // R5 busy
    run_op(0, 8'h45, 8'h00, 0, 1, 0, 1, 0, 0, 0, 8'h00, 1);  // R7 ack+busy
    run_op(1, 8'h46, 8'h00, 0, 0, 0, 0, 1, 1, 1, 8'h3c, 1);  // R7 over R8
    run_op(1, 8'h47, 8'h00, 0, 0, 0, 0, 1, 0, 1, 8'h3c, 2);  // R8 parity
    // random mix
    for (int i = 0; i < 300; i++) begin
      int lim, sd, dd;
      bit busy, sseq, dseq, badp, rd;
      lim  = int'($urandom_range(0, 6));
      sd   = int'($urandom_range(0, 7));
      dd   = int'($urandom_range(0, 7));
      rd   = 1'($urandom_range(0, 1));
      busy = ($urandom_range(0, 7) == 0);
      sseq = ($urandom_range(0, 9) == 0);
      dseq = ($urandom_range(0, 9) == 0);
      badp = ($urandom_range(0, 5) == 0);
      run_op(rd, 8'($urandom), 8'($urandom), lim, sd, busy, sseq, dd, dseq, badp,
             8'($urandom), int'($urandom_range(0, 3)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule